// File: doc/BRIEF.md
# Home Directory Coherence Engine

This block is the directory controller that sits beside a node's memory in a cache-coherent distributed shared memory machine. Each incoming message is a token: an opcode, the number of the node that sent it, and a line index. For every valid message the engine reads the stored entry for that line, which holds a state, an owner and a sharer bit vector. It computes the new entry and writes it back. In the same step it issues a reply to the sender, any forwarded intervention or data response, and a vector of invalidation targets.

The engine never stalls and never holds a request while it waits for another message. A line whose owner must first be consulted is parked in a transient busy state. The requestor gets a speculative reply, and the owner's transfer message later settles the entry. The engine also handles three other cases. A writeback that crosses a forwarded intervention is resolved by passing the written data on to the waiting owner. A re-request from an owner that silently dropped a clean line is served from memory. A line under migration can be poisoned, and every processor access to it then fails with a bus error. Memory data, the network and the caches are outside this block.

Top module: `dir_engine`

## Requirements
- R1: A read or read-exclusive (op 0/1) that finds a line Unowned, or Exclusive with the sender as owner, makes the sender the Exclusive owner with an empty sharer vector and replies exclusive (reply 1).
- R2: A read (op 0) that finds a line Shared adds the sender to the sharer vector and replies shared (reply 2).
- R3: A read that finds a line Exclusive with another owner moves it to Busy-shared with the sender as the new owner. It replies speculative (reply 3) and forwards a shared intervention (forward 1) to the previous owner.
- R4: A read, read-exclusive or upgrade that finds either busy state is answered with a negative acknowledgment (reply 4), and the entry is not changed.
- R5: A read-exclusive that finds a line Shared makes the sender the Exclusive owner. It replies exclusive-with-invalidations (reply 5) carrying the number of other sharers, and it asserts the invalidation bit of each sharer other than the sender.
- R6: A read-exclusive that finds a line Exclusive with another owner moves it to Busy-exclusive with the sender as new owner. It replies speculative and forwards an exclusive intervention (forward 2) to the previous owner.
- R7: An upgrade (op 2) on a Shared line makes the sender Exclusive owner, replies with a data-less grant (reply 6) carrying the ack count, and invalidates the other sharers; on Unowned, Exclusive or busy lines it is negatively acknowledged.
- R8: A writeback (op 3) from the owner of an Exclusive line makes it Unowned and is acknowledged (reply 7). A writeback that meets Busy-shared or Busy-exclusive does three things: it moves the line to Shared (holding only the waiting owner) or to Exclusive; it forwards the data to the waiting owner as a shared (forward 3) or exclusive (forward 4) response; and it replies writeback-busy (reply 8) to the writer.
- R9: A sharing writeback or sharing transfer (op 4/5) on a Busy-shared line makes it Shared with both the sender and the new owner as sharers. A dirty transfer (op 6) on a Busy-exclusive line makes it Exclusive with the new owner. Neither produces a reply.
- R10: A poison message (op 7) puts a line in the Poisoned state and is acknowledged (reply 10). Any read, read-exclusive, upgrade or writeback to a Poisoned line receives a bus error (reply 9). A clear message (op 8) returns a Poisoned line to Unowned with reply 10.
- R11: The error flag is raised, with no reply, forward or invalidation, and the entry is left unchanged, in these cases: an undefined opcode; a writeback to a line not owned by the sender and not busy; a transfer that does not match the busy state; a clear of a line that is not poisoned.
- R12: After reset every line is Unowned and all outputs are zero.
- R13: Outputs appear on the clock edge after the message is taken, last one cycle, and are zero in any cycle that follows no valid message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Message present this cycle |
| in_op | input | 4 | Message opcode |
| in_src | input | $clog2(NODES) | Sending node |
| in_line | input | $clog2(LINES) | Directory line index |
| rsp_type | output | 4 | Reply code to sender, 0 when none |
| rsp_dest | output | $clog2(NODES) | Node the reply goes to |
| rsp_acks | output | $clog2(NODES+1) | Invalidation acks the requestor must collect |
| fwd_type | output | 3 | Forwarded message code, 0 when none |
| fwd_dest | output | $clog2(NODES) | Node the forwarded message goes to |
| inval_vec | output | NODES | One bit per node to invalidate |
| err | output | 1 | Unexpected message for the line state |

## Verification
The directory state is not visible at the ports. A wrong internal entry therefore shows up at the next message that touches the same line, in the cycle after that message is accepted. It appears as the wrong reply class, a forward sent to the wrong node, or a wrong invalidation set. The stimulus is laid out so that each transition is followed by a probe on the same line. A corrupted owner, sharer vector or busy state is then exposed within one or two messages, and an update lost after an error is caught the same way.

// File: rtl/dir_engine.sv
module dir_engine #(
  parameter int NODES = 8,
  parameter int LINES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [3:0]                 in_op,
  input  logic [$clog2(NODES)-1:0]   in_src,
  input  logic [$clog2(LINES)-1:0]   in_line,
  output logic [3:0]                 rsp_type,
  output logic [$clog2(NODES)-1:0]   rsp_dest,
  output logic [$clog2(NODES+1)-1:0] rsp_acks,
  output logic [2:0]                 fwd_type,
  output logic [$clog2(NODES)-1:0]   fwd_dest,
  output logic [NODES-1:0]           inval_vec,
  output logic                       err
);
  localparam int NW = $clog2(NODES);
  localparam int CW = $clog2(NODES+1);

  localparam logic [2:0] S_UNO = 3'd0, S_SHD = 3'd1, S_EXC = 3'd2,
                         S_BSH = 3'd3, S_BEX = 3'd4, S_POI = 3'd5;

  localparam logic [3:0] OP_RD = 4'd0, OP_RX = 4'd1, OP_UP = 4'd2, OP_WB = 4'd3,
                         OP_SW = 4'd4, OP_SX = 4'd5, OP_DX = 4'd6, OP_PZ = 4'd7,
                         OP_CL = 4'd8;

  localparam logic [3:0] R_EXC = 4'd1, R_SHD = 4'd2, R_SPC = 4'd3, R_NAK = 4'd4,
                         R_XIN = 4'd5, R_UPG = 4'd6, R_WBA = 4'd7, R_WBB = 4'd8,
                         R_BER = 4'd9, R_DON = 4'd10;

  localparam logic [2:0] F_SIV = 3'd1, F_XIV = 3'd2, F_SDT = 3'd3, F_XDT = 3'd4;

  logic [2:0]       st  [LINES];
  logic [NW-1:0]    own [LINES];
  logic [NODES-1:0] shr [LINES];

  logic [2:0]       cs, ns;
  logic [NW-1:0]    co, no;
  logic [NODES-1:0] csh, nsh, me, others;
  logic [3:0]       r_t;
  logic [2:0]       f_t;
  logic [NW-1:0]    f_d;
  logic [NODES-1:0] iv;
  logic [CW-1:0]    cnt;
  logic             e, self_own;

  assign cs       = st[in_line];
  assign co       = own[in_line];
  assign csh      = shr[in_line];
  assign me       = NODES'(1) << in_src;
  assign others   = csh & ~me;
  assign self_own = (cs == S_EXC) && (co == in_src);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NODES; i++) cnt = cnt + CW'(others[i]);
  end

  always_comb begin
    ns = cs; no = co; nsh = csh;
    r_t = '0; f_t = '0; f_d = '0; iv = '0; e = 1'b0;
    case (in_op)
      OP_RD, OP_RX: begin
        if (cs == S_POI) r_t = R_BER;
        else if (cs == S_BSH || cs == S_BEX) r_t = R_NAK;
        else if (cs == S_UNO || self_own) begin
          ns = S_EXC; no = in_src; nsh = '0; r_t = R_EXC;
        end else if (cs == S_EXC) begin
          ns = (in_op == OP_RD) ? S_BSH : S_BEX; no = in_src;
          r_t = R_SPC; f_d = co; f_t = (in_op == OP_RD) ? F_SIV : F_XIV;
        end else if (in_op == OP_RD) begin
          nsh = csh | me; r_t = R_SHD;
        end else begin
          ns = S_EXC; no = in_src; nsh = '0; r_t = R_XIN; iv = others;
        end
      end
      OP_UP: begin
        if (cs == S_POI) r_t = R_BER;
        else if (cs == S_SHD) begin
          ns = S_EXC; no = in_src; nsh = '0; r_t = R_UPG; iv = others;
        end else r_t = R_NAK;
      end
      OP_WB: begin
        if (cs == S_POI) r_t = R_BER;
        else if (self_own) begin ns = S_UNO; nsh = '0; r_t = R_WBA; end
        else if (cs == S_BSH) begin
          ns = S_SHD; nsh = NODES'(1) << co; r_t = R_WBB; f_t = F_SDT; f_d = co;
        end else if (cs == S_BEX) begin
          ns = S_EXC; r_t = R_WBB; f_t = F_XDT; f_d = co;
        end else e = 1'b1;
      end
      OP_SW, OP_SX: begin
        if (cs == S_BSH) begin ns = S_SHD; nsh = me | (NODES'(1) << co); end
        else e = 1'b1;
      end
      OP_DX: begin
        if (cs == S_BEX) begin ns = S_EXC; nsh = '0; end
        else e = 1'b1;
      end
      OP_PZ: begin ns = S_POI; nsh = '0; r_t = R_DON; end
      OP_CL: begin
        if (cs == S_POI) begin ns = S_UNO; r_t = R_DON; end
        else e = 1'b1;
      end
      default: e = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i] <= S_UNO; own[i] <= '0; shr[i] <= '0;
      end
      rsp_type <= '0; rsp_dest <= '0; rsp_acks <= '0;
      fwd_type <= '0; fwd_dest <= '0; inval_vec <= '0; err <= 1'b0;
    end else begin
      rsp_type  <= in_valid ? r_t : '0;
      rsp_dest  <= in_valid ? in_src : '0;
      rsp_acks  <= (in_valid && (r_t == R_XIN || r_t == R_UPG)) ? cnt : '0;
      fwd_type  <= in_valid ? f_t : '0;
      fwd_dest  <= in_valid ? f_d : '0;
      inval_vec <= in_valid ? iv : '0;
      err       <= in_valid & e;
      if (in_valid && !e) begin
        st[in_line] <= ns; own[in_line] <= no; shr[in_line] <= nsh;
      end
    end
  end

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (rsp_type == 4'd0 && fwd_type == 3'd0 && !err && inval_vec == '0));

  a_r11_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rsp_type == 4'd0 && fwd_type == 3'd0 && inval_vec == '0));

  a_r5_ack_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_type == R_XIN || rsp_type == R_UPG) |-> ($countones(inval_vec) == int'(rsp_acks)));

  a_r5_no_self_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_type != 4'd0) |-> !inval_vec[rsp_dest]);

  a_r4_nak_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_type == R_NAK) |-> (fwd_type == 3'd0 && inval_vec == '0));

  a_r3_intervention_spec: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_type == F_SIV || fwd_type == F_XIV) |-> (rsp_type == R_SPC && fwd_dest != rsp_dest));

  a_r8_bounce_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_type == F_SDT || fwd_type == F_XDT) |-> (rsp_type == R_WBB));
endmodule

// File: tb/dir_engine_tb.sv
`timescale 1ns/1ps
module dir_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic [2:0] in_src = '0;
  logic [3:0] in_line = '0;
  logic [3:0] rsp_type;
  logic [2:0] rsp_dest;
  logic [3:0] rsp_acks;
  logic [2:0] fwd_type;
  logic [2:0] fwd_dest;
  logic [7:0] inval_vec;
  logic       err;

  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  dir_engine dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src(in_src), .in_line(in_line), .rsp_type(rsp_type), .rsp_dest(rsp_dest),
    .rsp_acks(rsp_acks), .fwd_type(fwd_type), .fwd_dest(fwd_dest),
    .inval_vec(inval_vec), .err(err));

  // {req, op, src, line, rsp, acks, fwd, fdst, inval, err}
  localparam int NV = 40;
  localparam logic [37:0] VEC [NV] = '{
    {4'd1, 4'd0,3'd1,4'd0, 4'd1,4'd0,3'd0,3'd0,8'h00,1'b0},  // R1 unowned read
    {4'd1, 4'd0,3'd1,4'd0, 4'd1,4'd0,3'd0,3'd0,8'h00,1'b0},  // R1 owner re-request
    {4'd3, 4'd0,3'd2,4'd0, 4'd3,4'd0,3'd1,3'd1,8'h00,1'b0},  // R3 busy-shared
    {4'd4, 4'd0,3'd3,4'd0, 4'd4,4'd0,3'd0,3'd0,8'h00,1'b0},  // R4
    {4'd4, 4'd2,3'd3,4'd0, 4'd4,4'd0,3'd0,3'd0,8'h00,1'b0},  // R4
    {4'd4, 4'd1,3'd3,4'd0, 4'd4,4'd0,3'd0,3'd0,8'h00,1'b0},  // R4
    {4'd9, 4'd4,3'd1,4'd0, 4'd0,4'd0,3'd0,3'd0,8'h00,1'b0},  // R9 sharing writeback
    {4'd2, 4'd0,3'd3,4'd0, 4'd2,4'd0,3'd0,3'd0,8'h00,1'b0},  // R2
    {4'd7, 4'd2,3'd2,4'd0, 4'd6,4'd2,3'd0,3'd0,8'h0A,1'b0},  // R7 upgrade
    {4'd6, 4'd1,3'd5,4'd0, 4'd3,4'd0,3'd2,3'd2,8'h00,1'b0},  // R6
    {4'd8, 4'd3,3'd2,4'd0, 4'd8,4'd0,3'd4,3'd5,8'h00,1'b0},  // R8 bounce excl
    {4'd8, 4'd3,3'd5,4'd0, 4'd7,4'd0,3'd0,3'd0,8'h00,1'b0},  // R8 owner wb
    {4'd7, 4'd2,3'd4,4'd0, 4'd4,4'd0,3'd0,3'd0,8'h00,1'b0},  // R7 nak
    {4'd1, 4'd1,3'd4,4'd0, 4'd1,4'd0,3'd0,3'd0,8'h00,1'b0},  // R1 rdex unowned
    {4'd3, 4'd0,3'd6,4'd0, 4'd3,4'd0,3'd1,3'd4,8'h00,1'b0},  // R3
    {4'd8, 4'd3,3'd4,4'd0, 4'd8,4'd0,3'd3,3'd6,8'h00,1'b0},  // R8 bounce shared
    {4'd2, 4'd0,3'd7,4'd0, 4'd2,4'd0,3'd0,3'd0,8'h00,1'b0},  // R2
    {4'd5, 4'd1,3'd0,4'd0, 4'd5,4'd2,3'd0,3'd0,8'hC0,1'b0},  // R5
    {4'd11,4'd5,3'd1,4'd0, 4'd0,4'd0,3'd0,3'd0,8'h00,1'b1},  // R11 stray transfer
    {4'd11,4'd0,3'd0,4'd0, 4'd1,4'd0,3'd0,3'd0,8'h00,1'b0},  // R11 entry kept
    {4'd1, 4'd0,3'd3,4'd1, 4'd1,4'd0,3'd0,3'd0,8'h00,1'b0},  // R1
    {4'd6, 4'd1,3'd0,4'd1, 4'd3,4'd0,3'd2,3'd3,8'h00,1'b0},  // R6
    {4'd9, 4'd6,3'd3,4'd1, 4'd0,4'd0,3'd0,3'd0,8'h00,1'b0},  // R9 dirty transfer
    {4'd9, 4'd0,3'd0,4'd1, 4'd1,4'd0,3'd0,3'd0,8'h00,1'b0},  // R9 new owner
    {4'd10,4'd7,3'd0,4'd1, 4'd10,4'd0,3'd0,3'd0,8'h00,1'b0}, // R10 poison
    {4'd10,4'd0,3'd2,4'd1, 4'd9,4'd0,3'd0,3'd0,8'h00,1'b0},  // R10
    {4'd10,4'd3,3'd0,4'd1, 4'd9,4'd0,3'd0,3'd0,8'h00,1'b0},  // R10
    {4'd10,4'd2,3'd2,4'd1, 4'd9,4'd0,3'd0,3'd0,8'h00,1'b0},  // R10
    {4'd10,4'd1,3'd2,4'd1, 4'd9,4'd0,3'd0,3'd0,8'h00,1'b0},  // R10
    {4'd10,4'd8,3'd1,4'd1, 4'd10,4'd0,3'd0,3'd0,8'h00,1'b0}, // R10 clear
    {4'd10,4'd0,3'd2,4'd1, 4'd1,4'd0,3'd0,3'd0,8'h00,1'b0},  // R10 unowned again
    {4'd1, 4'd0,3'd1,4'd2, 4'd1,4'd0,3'd0,3'd0,8'h00,1'b0},  // R1
    {4'd3, 4'd0,3'd2,4'd2, 4'd3,4'd0,3'd1,3'd1,8'h00,1'b0},  // R3
    {4'd9, 4'd5,3'd1,4'd2, 4'd0,4'd0,3'd0,3'd0,8'h00,1'b0},  // R9 sharing transfer
    {4'd5, 4'd1,3'd3,4'd2, 4'd5,4'd2,3'd0,3'd0,8'h06,1'b0},  // R5
    {4'd11,4'd3,3'd4,4'd2, 4'd0,4'd0,3'd0,3'd0,8'h00,1'b1},  // R11 foreign wb
    {4'd11,4'd6,3'd4,4'd2, 4'd0,4'd0,3'd0,3'd0,8'h00,1'b1},  // R11 dirty xfer
    {4'd11,4'd15,3'd0,4'd3,4'd0,4'd0,3'd0,3'd0,8'h00,1'b1},  // R11 bad op
    {4'd11,4'd0,3'd0,4'd3, 4'd1,4'd0,3'd0,3'd0,8'h00,1'b0},  // R11 line kept
    {4'd11,4'd8,3'd0,4'd3, 4'd0,4'd0,3'd0,3'd0,8'h00,1'b1}   // R11 clear unpoisoned
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " rsp"}, rsp_type, 0);
    chk({tag, " fwd"}, fwd_type, 0);
    chk({tag, " inval"}, inval_vec, 0);
    chk({tag, " err"}, err, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_quiet("R12 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_quiet("R13 idle");
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      string t;
      v = VEC[i];
      in_valid = 1'b1; in_op = v[33:30]; in_src = v[29:27]; in_line = v[26:23];
      @(negedge clk);
      t = $sformatf("R%0d vec%0d", v[37:34], i);
      chk({t, " rsp"}, rsp_type, v[22:19]);
      chk({t, " acks"}, rsp_acks, v[18:15]);
      chk({t, " fwd"}, fwd_type, v[14:12]);
      if (v[14:12] != 0) chk({t, " fdst"}, fwd_dest, v[11:9]);
      if (v[22:19] != 0) chk({t, " rdst"}, rsp_dest, v[29:27]);
      chk({t, " inval"}, inval_vec, v[8:1]);
      chk({t, " err"}, err, v[0]);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk_quiet("R13 one-cycle pulse");
    in_valid = 1'b1; in_op = 4'd7; in_src = 3'd0; in_line = 4'd0;
    @(negedge clk);
    chk("R10 poison before reset", rsp_type, 10);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk_quiet("R12 reset mid-run");
    rst_n = 1'b1;
    in_valid = 1'b1; in_op = 4'd0; in_src = 3'd5; in_line = 4'd0;
    @(negedge clk);
    chk("R12 line unowned after reset", rsp_type, 1);
    in_op = 4'd0; in_src = 3'd6; in_line = 4'd1;
    @(negedge clk);
    chk("R12 second line unowned", rsp_type, 1);
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule